// File: doc/BRIEF.md
# Preamble Quality Estimator

This block watches the stream of demodulated bits that a receiver produces while it waits for a packet and scores how closely that stream looks like a preamble, which is a run of alternating ones and zeros. Every accepted bit that differs from the bit before it adds one to a small score. Every accepted bit that repeats the bit before it takes eight away. The score stops at zero and at its ceiling and never wraps. Random noise repeats bits often, so the score stays low. A clean preamble makes the score climb steadily.

A 3-bit threshold setting selects the level at which the quality flag comes on. The level is four times the setting. A setting of zero turns the check off, and the flag is then always on. The sync-word search can gate its matches with the flag, so that noise is less likely to produce a false sync. The block also forms a hold-reception signal for the receive-timeout logic. When the timer runs out, reception continues if a sync word has been found. If qualification by preamble quality is enabled, reception also continues when the flag is on.

Bits arrive as a valid strobe with a data bit. There is no ready signal: the block accepts a bit on every cycle the strobe is high and never applies back-pressure. The restart input clears the score and the stored bit whenever reception is entered or restarted.

Top module: `preamble_quality_est`

## Requirements
- R1: After reset, score_o is 0 and no previous bit is stored.
- R2: The first bit accepted after reset or restart only stores that bit. score_o does not change.
- R3: An accepted bit that differs from the stored previous bit raises score_o by 1.
- R4: At 31, the ceiling of the 5-bit score, a differing bit leaves score_o at 31.
- R5: An accepted bit equal to the stored previous bit lowers score_o by 8, or sets it to 0 if it is below 8.
- R6: In a cycle with bit_valid_i low and rx_restart_i low, score_o and the stored bit hold their values.
- R7: rx_restart_i clears score_o to 0 and forgets the stored bit on the next edge. It takes priority over a strobe in the same cycle, and that bit is discarded.
- R8: quality_ok_o is 1 when score_o >= 4 * thr_sel_i. With thr_sel_i = 0 it is always 1. It is combinational from score_o and thr_sel_i.
- R9: rx_hold_o equals sync_found_i OR (qual_en_i AND quality_ok_o).
- R10: A strobe sampled at a rising edge is reflected in score_o and quality_ok_o right after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_restart_i | input | 1 | Entry into reception or restart of it; clears the score |
| bit_valid_i | input | 1 | Strobe: bit_i holds a new demodulated bit |
| bit_i | input | 1 | Demodulated data bit |
| thr_sel_i | input | 3 | Threshold setting; level = 4 * setting, 0 turns the check off |
| sync_found_i | input | 1 | Sync word detected by the correlator |
| qual_en_i | input | 1 | Lets the quality flag keep reception alive at timeout |
| score_o | output | 5 | Saturating preamble score |
| quality_ok_o | output | 1 | Score has reached the threshold |
| rx_hold_o | output | 1 | Keep reception going when the timeout expires |

## Verification
A wrong stored previous bit turns the next transition into a repeat, or the other way round. score_o then moves by 8 where it should move by 1, and this shows right after the edge that samples the next strobe. A lost first-bit marker shows as a score change on the first bit after restart. A bad clamp shows as a score that wraps near 0 or near 31 within one strobe. A bad threshold comparison shows on quality_ok_o and rx_hold_o in the same cycle as the score it depends on. The sweeps go through every threshold setting with alternating, repeated and pseudo-random bit patterns, so each of these faults shows within a few strobes.

// File: rtl/pqe_pkg.sv
package pqe_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } pqe_step_e;
endpackage

// File: rtl/pqe_bit_track.sv
module pqe_bit_track
  import pqe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart_i,
  input  logic      valid_i,
  input  logic      bit_i,
  output pqe_step_e step_o,
  output logic      have_prev_o
);
  logic prev_q;
  logic have_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= bit_i;
      have_q <= 1'b1;
    end
  end

  always_comb begin
    step_o = STEP_NONE;
    if (valid_i && !restart_i && have_q)
      step_o = (bit_i != prev_q) ? STEP_UP : STEP_DOWN;
  end

  assign have_prev_o = have_q;

  // R6: the stored bit is kept while no strobe arrives
  assert_prev_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !restart_i) |=> (prev_q == $past(prev_q) && have_q == $past(have_q)));

  // R2: an accepted bit is stored for the next comparison
  assert_prev_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !restart_i) |=> (have_q && prev_q == $past(bit_i)));
endmodule

// File: rtl/pqe_score.sv
module pqe_score
  import pqe_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int INC_STEP = 1,
  parameter int DEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  pqe_step_e        step_i,
  output logic [CNT_W-1:0] score_o
);
  localparam logic [CNT_W:0] MAX_V = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0] INC_V = (CNT_W+1)'(INC_STEP);
  localparam logic [CNT_W:0] DEC_V = (CNT_W+1)'(DEC_STEP);

  logic [CNT_W-1:0] score_q;
  logic [CNT_W-1:0] score_d;
  logic [CNT_W:0]   ext;
  logic [CNT_W:0]   sum;

  assign ext = {1'b0, score_q};
  assign sum = ext + INC_V;

  always_comb begin
    score_d = score_q;
    unique case (step_i)
      STEP_UP:   score_d = (sum > MAX_V) ? MAX_V[CNT_W-1:0] : sum[CNT_W-1:0];
      STEP_DOWN: score_d = (ext >= DEC_V) ? (ext - DEC_V) : '0;
      default:   score_d = score_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) score_q <= '0;
    else                     score_q <= score_d;
  end

  assign score_o = score_q;

  // R4: the ceiling holds under further transitions
  assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_UP && ext == MAX_V && !restart_i) |=> (score_q == MAX_V[CNT_W-1:0]));

  // R5: drops below the step size clamp at zero
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_DOWN && ext < DEC_V && !restart_i) |=> (score_q == '0));

  // R7: restart empties the score
  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (score_q == '0));
endmodule

// File: rtl/pqe_qual_cmp.sv
module pqe_qual_cmp #(
  parameter int CNT_W     = 5,
  parameter int THR_W     = 3,
  parameter int THR_SCALE = 4
) (
  input  logic [CNT_W-1:0] score_i,
  input  logic [THR_W-1:0] thr_sel_i,
  output logic             ok_o
);
  localparam int TW = THR_W + $clog2(THR_SCALE) + 1;
  localparam int CW = (TW > CNT_W) ? TW : CNT_W;

  logic [CW-1:0] level;
  logic [CW-1:0] score_ext;

  generate
    if ((THR_SCALE & (THR_SCALE - 1)) == 0) begin : g_shift
      assign level = CW'(thr_sel_i) << $clog2(THR_SCALE);
    end else begin : g_mul
      assign level = CW'(thr_sel_i) * CW'(THR_SCALE);
    end
  endgenerate

  assign score_ext = CW'(score_i);
  assign ok_o = (thr_sel_i == '0) || (score_ext >= level);
endmodule

// File: rtl/preamble_quality_est.sv
module preamble_quality_est
  import pqe_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int THR_W     = 3,
  parameter int THR_SCALE = 4,
  parameter int INC_STEP  = 1,
  parameter int DEC_STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_restart_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic [THR_W-1:0] thr_sel_i,
  input  logic             sync_found_i,
  input  logic             qual_en_i,
  output logic [CNT_W-1:0] score_o,
  output logic             quality_ok_o,
  output logic             rx_hold_o
);
  localparam logic [CNT_W-1:0] SCORE_MAX = {CNT_W{1'b1}};

  pqe_step_e step;
  logic      have_prev;

  pqe_bit_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (rx_restart_i),
    .valid_i     (bit_valid_i),
    .bit_i       (bit_i),
    .step_o      (step),
    .have_prev_o (have_prev)
  );

  pqe_score #(
    .CNT_W    (CNT_W),
    .INC_STEP (INC_STEP),
    .DEC_STEP (DEC_STEP)
  ) u_score (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (rx_restart_i),
    .step_i    (step),
    .score_o   (score_o)
  );

  pqe_qual_cmp #(
    .CNT_W     (CNT_W),
    .THR_W     (THR_W),
    .THR_SCALE (THR_SCALE)
  ) u_cmp (
    .score_i   (score_o),
    .thr_sel_i (thr_sel_i),
    .ok_o      (quality_ok_o)
  );

  assign rx_hold_o = sync_found_i | (qual_en_i & quality_ok_o);

  // R2: the first bit after restart leaves the score alone
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid_i && !rx_restart_i && !have_prev) |=> $stable(score_o));

  // R3: a transition below the ceiling adds one
  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_UP && score_o != SCORE_MAX) |=> (score_o == $past(score_o) + CNT_W'(INC_STEP)));

  // R5: a repeat from a high enough score subtracts the full step
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_DOWN && score_o >= CNT_W'(DEC_STEP)) |=> (score_o == $past(score_o) - CNT_W'(DEC_STEP)));

  // R6: no strobe, no change
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid_i && !rx_restart_i) |=> $stable(score_o));

  // R7: after restart, no stored bit remains
  assert_restart_forget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart_i |=> !have_prev);
endmodule

// File: tb/preamble_quality_est_bench.sv
module preamble_quality_est_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_restart_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [2:0] thr_sel_i = 3'd0;
  logic       sync_found_i = 1'b0;
  logic       qual_en_i = 1'b0;
  logic [4:0] score_o;
  logic       quality_ok_o;
  logic       rx_hold_o;

  int checks = 0;
  int errors = 0;
  int m_score = 0;
  int m_prev = 0;
  int m_have = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  preamble_quality_est u_preamble_quality_est (
    .clk(clk), .rst_n(rst_n), .rx_restart_i(rx_restart_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .thr_sel_i(thr_sel_i),
    .sync_found_i(sync_found_i), .qual_en_i(qual_en_i),
    .score_o(score_o), .quality_ok_o(quality_ok_o), .rx_hold_o(rx_hold_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_flag(input int s, input int t);
    return (t == 0 || s >= 4 * t) ? 1 : 0;
  endfunction

  // drive one cycle, update model, check right after the edge (R10)
  task automatic cycle(input logic v, input logic b, input logic r, input string req);
    @(negedge clk);
    bit_valid_i = v; bit_i = b; rx_restart_i = r;
    if (r) begin
      m_score = 0; m_have = 0; m_prev = 0;
    end else if (v) begin
      if (m_have == 0) begin
        m_have = 1;
      end else if (int'(b) != m_prev) begin
        m_score = (m_score + 1 > 31) ? 31 : m_score + 1;
      end else begin
        m_score = (m_score < 8) ? 0 : m_score - 8;
      end
      m_prev = int'(b);
    end
    @(posedge clk);
    #2;
    chk(req, int'(score_o), m_score);
    chk("R8 flag", int'(quality_ok_o), exp_flag(m_score, int'(thr_sel_i)));
    bit_valid_i = 1'b0; rx_restart_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset score", int'(score_o), 0);
    chk("R8 reset flag thr0", int'(quality_ok_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R2: first bit after reset stores only
    cycle(1'b1, 1'b1, 1'b0, "R1 R2 first bit after reset");
    cycle(1'b1, 1'b0, 1'b0, "R3 first transition");

    for (int t = 0; t < 8; t++) begin
      thr_sel_i = 3'(t);
      cycle(1'b0, 1'b0, 1'b1, "R7 restart");
      cycle(1'b1, 1'b1, 1'b0, "R2 first bit ignored");
      // alternating run up to saturation (R3, R4)
      for (int i = 0; i < 40; i++) cycle(1'b1, 1'(i), 1'b0, "R3 R4 alternating");
      chk("R4 ceiling", int'(score_o), 31);
      // idle cycles (R6)
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b0, "R6 idle hold");
      // repeats falling to zero (R5)
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'(m_prev), 1'b0, "R5 repeat");
      chk("R5 floor", int'(score_o), 0);
      // pseudo-random bits
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cycle(lfsr[0], lfsr[1], 1'b0, "R3 R5 random");
      end
      // mostly alternating with sparse repeats
      for (int i = 0; i < 30; i++) cycle(1'b1, (i % 7 == 6) ? 1'(m_prev) : 1'(~m_prev[0]), 1'b0, "R3 R5 sparse repeats");
      // restart with a strobe in the same cycle (R7)
      cycle(1'b1, 1'(~m_prev[0]), 1'b1, "R7 restart priority");
      cycle(1'b1, 1'b0, 1'b0, "R7 next bit is first");
      cycle(1'b1, 1'b1, 1'b0, "R3 after restart");
    end

    // R9: hold output over all input combinations, flag off and on
    for (int f = 0; f < 2; f++) begin
      thr_sel_i = (f == 0) ? 3'd7 : 3'd0;
      cycle(1'b0, 1'b0, 1'b1, "R7 restart before R9");
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        sync_found_i = k[0]; qual_en_i = k[1];
        #1;
        chk("R9 hold", int'(rx_hold_o), (k[0] || (k[1] && f == 1)) ? 1 : 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule